// File: doc/BRIEF.md
# PWM Duty Sample Queue

This block buffers duty-cycle samples on their way to a pulse-width generator. Software writes 32-bit words. A configurable half selector picks the upper or the lower 16 bits of each word, and an optional byte reversal is applied to that half. The resulting 16-bit sample joins a four-deep first-in first-out queue. The generator core drains the queue through a single pop strobe and reads each sample from a registered output.

The block reports how many samples it holds. It raises a threshold flag when the number of free slots reaches a programmable level, so software knows when to refill. A write that arrives when the queue is full is discarded, and it sets an error flag that stays set until software clears it. The half selection, byte order and threshold are held in a small configuration register. That register loads on a strobe and resets to a threshold code of 1.

Top module: `pwm_sample_queue`

## Requirements
- R1: Samples leave the queue in the order they entered. A pop accepted at a clock edge places the head sample on `pop_data` right after that edge, and `pop_data` keeps that value until the next accepted pop.
- R2: When the stored half-select bit is 1, the sample is taken from bits [31:16] of `push_data`. When it is 0, the sample is taken from bits [15:0].
- R3: When the stored byte-order bit is 1, bits [15:8] and [7:0] of the selected half trade places before the sample is stored. When it is 0, the half is stored unchanged.
- R4: `level` reports 0 to 4 stored samples. An accepted push adds one and an accepted pop removes one. When both are accepted in the same cycle, `level` does not change.
- R5: Whether a push is accepted depends on `level` before the edge. A push while `level` is 4 is dropped, even if a pop happens in the same cycle, and the stored samples stay as they were.
- R6: A dropped push sets `wr_err` at that clock edge. `wr_err` then stays at 1.
- R7: `err_clr` high at an edge clears `wr_err`. If a dropped push happens in the same cycle, the set wins and `wr_err` stays 1.
- R8: `room_flag` is 1 exactly when (4 - `level`) >= (threshold code + 1). The threshold code is the 2-bit field: 0 means at least 1 free slot, 1 means at least 2, 2 means at least 3, and 3 means 4 free slots.
- R9: While `cfg_wr` is high, the half-select bit, the byte-order bit and the threshold code are loaded at the edge. They apply from the next cycle on and are held while `cfg_wr` is low. After reset they are 0, 0 and 1.
- R10: A pop while `level` is 0 is ignored. `pop_data` keeps the last popped value and `level` is unchanged.
- R11: After reset, `level` is 0, `pop_data` is 0 and `wr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_half_hi | input | 1 | Half select: 1 takes the upper half |
| cfg_byte_rev | input | 1 | Byte order: 1 swaps the two bytes |
| cfg_wmark | input | 2 | Free-slot threshold code |
| push | input | 1 | Write strobe for a new word |
| push_data | input | 32 | Written word |
| pop | input | 1 | Sample request from the generator core |
| pop_data | output | 16 | Last popped sample |
| level | output | 3 | Number of stored samples |
| room_flag | output | 1 | Free-slot threshold reached |
| wr_err | output | 1 | Sticky flag for a dropped write |
| err_clr | input | 1 | Write-one-to-clear for `wr_err` |

## Verification
The bench builds the block with its default values: depth 4, 16-bit samples and a 32-bit bus. At this size the bench can visit every threshold code at every fill level from 0 to 4, and it can try every combination of half select and byte order on several data patterns. The small depth also makes the full and empty edges easy to reach, so the bench can test a push on a full queue, a push and a pop together on a full queue, a pop on an empty queue, and a push and a pop together on an empty queue. A cycle-level model in the bench computes every expected value.

// File: rtl/pwm_sq_pkg.sv
package pwm_sq_pkg;
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_sel_e;

    typedef enum logic {
        BYTES_KEEP    = 1'b0,
        BYTES_REVERSE = 1'b1
    } byte_ord_e;
endpackage

// File: rtl/sq_write_path.sv
module sq_write_path
    import pwm_sq_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int SAMPLE_W = 16
) (
    input  logic [BUS_W-1:0]    wr_data,
    input  half_sel_e           half,
    input  byte_ord_e           order,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int NBYTES = SAMPLE_W / 8;

    logic [SAMPLE_W-1:0] picked;
    logic [SAMPLE_W-1:0] reversed;

    always_comb begin
        if (half == HALF_HIGH) picked = wr_data[BUS_W-1 -: SAMPLE_W];
        else                   picked = wr_data[SAMPLE_W-1:0];
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign reversed[g*8 +: 8] = picked[(NBYTES-1-g)*8 +: 8];
    end

    assign sample = (order == BYTES_REVERSE) ? reversed : picked;

    initial begin
        assert (BUS_W == 2 * SAMPLE_W && SAMPLE_W % 8 == 0)
            else $error("bad widths");
    end
endmodule

// File: rtl/sq_storage.sv
module sq_storage #(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 16,
    parameter int PTR_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] dout,
    output logic [CNT_W-1:0]    count,
    output logic                push_rej
);
    typedef struct packed {
        logic [DEPTH-1:0][SAMPLE_W-1:0] mem;
        logic [PTR_W-1:0]               rd;
        logic [PTR_W-1:0]               wr;
        logic [CNT_W-1:0]               cnt;
        logic [SAMPLE_W-1:0]            out;
    } st_t;

    st_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        if (do_pop) begin
            st_d.out = st_q.mem[st_q.rd];
            st_d.rd  = next_ptr(st_q.rd);
        end
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = next_ptr(st_q.wr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.out;
    assign count    = st_q.cnt;
    assign push_rej = push && (st_q.cnt == CNT_W'(DEPTH));

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt == CNT_W'(DEPTH)) |=>
        (st_q.cnt == CNT_W'(DEPTH) && $stable(st_q.mem)));

    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> ($stable(st_q.out) && st_q.cnt == '0));
endmodule

// File: rtl/sq_status.sv
module sq_status #(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int WM_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [WM_W-1:0]  wmark,
    input  logic             push_rej,
    input  logic             clr,
    output logic             room,
    output logic             err
);
    logic             err_d, err_q;
    logic [CNT_W:0]   free_slots;
    logic [CNT_W:0]   needed;

    always_comb begin
        free_slots = (CNT_W+1)'(DEPTH) - (CNT_W+1)'(count);
        needed     = (CNT_W+1)'(wmark) + (CNT_W+1)'(1);
        room       = free_slots >= needed;
        err_d      = err_q;
        if (clr)      err_d = 1'b0;
        if (push_rej) err_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err = err_q;

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_rej |=> err);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !push_rej) |=> !err);

    assert_room_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> room);
endmodule

// File: rtl/pwm_sample_queue.sv
module pwm_sample_queue
    import pwm_sq_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int SAMPLE_W = 16,
    parameter int BUS_W    = 32,
    parameter int WM_W     = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int WM_RESET = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_half_hi,
    input  logic                cfg_byte_rev,
    input  logic [WM_W-1:0]     cfg_wmark,
    input  logic                push,
    input  logic [BUS_W-1:0]    push_data,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] pop_data,
    output logic [CNT_W-1:0]    level,
    output logic                room_flag,
    output logic                wr_err,
    input  logic                err_clr
);
    typedef struct packed {
        half_sel_e        half;
        byte_ord_e        order;
        logic [WM_W-1:0]  wm;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [SAMPLE_W-1:0] sample;
    logic                push_rej;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.half  = half_sel_e'(cfg_half_hi);
            cfg_d.order = byte_ord_e'(cfg_byte_rev);
            cfg_d.wm    = cfg_wmark;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{half: HALF_LOW, order: BYTES_KEEP, wm: WM_W'(WM_RESET)};
        else        cfg_q <= cfg_d;
    end

    sq_write_path #(.BUS_W(BUS_W), .SAMPLE_W(SAMPLE_W)) i_wpath (
        .wr_data (push_data),
        .half    (cfg_q.half),
        .order   (cfg_q.order),
        .sample  (sample)
    );

    sq_storage #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .din      (sample),
        .pop      (pop),
        .dout     (pop_data),
        .count    (level),
        .push_rej (push_rej)
    );

    sq_status #(.DEPTH(DEPTH)) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (level),
        .wmark    (cfg_q.wm),
        .push_rej (push_rej),
        .clr      (err_clr),
        .room     (room_flag),
        .err      (wr_err)
    );

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/test_pwm_sample_queue.sv
`timescale 1ns/1ps
module test_pwm_sample_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_half_hi = 1'b0, cfg_byte_rev = 1'b0;
    logic [1:0]  cfg_wmark = 2'd0;
    logic        push = 1'b0, pop = 1'b0, err_clr = 1'b0;
    logic [31:0] push_data = '0;
    logic [15:0] pop_data;
    logic [2:0]  level;
    logic        room_flag, wr_err;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [15:0] mq [4];
    int          mcnt = 0;
    logic [15:0] mout = '0;
    logic        merr = 1'b0;
    logic        mh = 1'b0, mb = 1'b0;
    int          mwm = 1;

    always #2.5 clk = ~clk;

    pwm_sample_queue i_pwm_sample_queue (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_half_hi(cfg_half_hi),
        .cfg_byte_rev(cfg_byte_rev), .cfg_wmark(cfg_wmark), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data), .level(level),
        .room_flag(room_flag), .wr_err(wr_err), .err_clr(err_clr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] shape(input logic [31:0] w, input logic h, input logic b);
        logic [15:0] s;
        s = h ? w[31:16] : w[15:0];
        return b ? {s[7:0], s[15:8]} : s;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input string tag, input logic p, input logic [31:0] d,
                       input logic q, input logic c);
        logic rej;
        push = p; push_data = d; pop = q; err_clr = c;
        rej = p && (mcnt == 4);
        if (q && mcnt > 0) begin
            mout = mq[0];
            for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
            mcnt--;
        end
        if (p && !rej) begin
            mq[mcnt] = shape(d, mh, mb);
            mcnt++;
        end
        if (c) merr = 1'b0;
        if (rej) merr = 1'b1;
        tick();
        push = 0; pop = 0; err_clr = 0;
        check(tag, "level", int'(level), mcnt);
        check(tag, "pop_data", int'(pop_data), int'(mout));
        check(tag, "wr_err", int'(wr_err), int'(merr));
        check(tag, "room_flag", int'(room_flag), int'((4 - mcnt) >= (mwm + 1)));
    endtask

    task automatic setcfg(input logic h, input logic b, input int wm);
        cfg_wr = 1; cfg_half_hi = h; cfg_byte_rev = b; cfg_wmark = 2'(wm);
        tick();
        cfg_wr = 0;
        mh = h; mb = b; mwm = wm;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state and R9 default threshold code 1
        check("R11", "level", int'(level), 0);
        check("R11", "pop_data", int'(pop_data), 0);
        check("R11", "wr_err", int'(wr_err), 0);
        check("R9", "room_flag", int'(room_flag), 1);
        rst_n = 1'b1;
        tick();
        // R9 default threshold: flag drops at level 3 (1 free < 2)
        for (int i = 0; i < 4; i++) cyc("R9", 1, 32'h1000 + i, 0, 0);
        // R1 ordering with default config
        for (int i = 0; i < 4; i++) cyc("R1", 0, 0, 1, 0);
        // R2 R3 all select combinations over several patterns
        for (int cf = 0; cf < 4; cf++) begin
            setcfg(cf[0], cf[1], 1);
            cyc("R2", 1, 32'hA1B2_C3D4, 0, 0);
            cyc("R3", 1, 32'h0FF0_1234, 0, 0);
            cyc("R2", 1, 32'h8001_7FFE, 0, 0);
            for (int k = 0; k < 3; k++) cyc("R3", 0, 0, 1, 0);
        end
        // R8 every threshold at every level
        for (int wm = 0; wm < 4; wm++) begin
            setcfg(0, 0, wm);
            for (int i = 0; i < 4; i++) cyc("R8", 1, 32'(wm * 16 + i), 0, 0);
            for (int i = 0; i < 4; i++) cyc("R8", 0, 0, 1, 0);
        end
        setcfg(1, 1, 2);
        // R4 simultaneous push and pop at level 2
        cyc("R4", 1, 32'h1111_2222, 0, 0);
        cyc("R4", 1, 32'h3333_4444, 0, 0);
        cyc("R4", 1, 32'h5555_6666, 1, 0);
        cyc("R4", 1, 32'h7777_8888, 0, 0);
        cyc("R4", 1, 32'h9999_AAAA, 0, 0);
        // R5 R6 push on full dropped, error set
        cyc("R5", 1, 32'hDEAD_BEEF, 0, 0);
        cyc("R6", 0, 0, 0, 0);
        // R5 push with pop on full: pop accepted, push dropped
        cyc("R5", 1, 32'hCAFE_F00D, 1, 0);
        // R7 clear alone
        cyc("R7", 0, 0, 0, 1);
        cyc("R5", 1, 32'h0BAD_0BAD, 0, 0);
        // R7 clear with dropped push: set wins
        cyc("R7", 1, 32'h1234_5678, 0, 1);
        cyc("R7", 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc("R5", 0, 0, 1, 0);
        // R10 pop on empty, then push and pop together on empty
        cyc("R10", 0, 0, 1, 0);
        cyc("R10", 0, 0, 1, 0);
        cyc("R10", 1, 32'h4321_8765, 1, 0);
        cyc("R1", 0, 0, 1, 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule